// File: doc/BRIEF.md
# Read-Pattern Command Detector for a Byte-Wide Memory Bus

This block watches a 32K x 8 asynchronous memory bus that has no command pins. It turns two fixed, ordered runs of six read addresses into commands. One run asks the nonvolatile backing store to capture the array, which is a STORE. The other asks for the array to be reloaded from that store, which is a RECALL. The bus signals (address, chip enable, write enable) are sampled in the system clock domain. One access is counted on each falling edge of chip enable. Output enable has no part in the detection, so the block does not take it as an input.

When a run completes, the block raises a one-cycle request pulse for the matching command. It then holds a busy flag for a parameterised number of clock cycles, which stand in for the length of the operation. Any access that breaks the run sends the detector back to idle, and nothing is issued. A read of the first pattern address restarts the run at step one. While busy, the block ignores bus activity.

Both patterns open with reads of 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F. The sixth address picks the command: 0x0C63 means RECALL and 0x0FC0 means STORE.

Top module: `nvSeqDetect`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, storeReq, recallReq and busy are all low, and the detector is at step zero.
- R2: Six chip-enable falling edges that read 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and 0x0C63, in that order, raise recallReq for exactly one cycle. The pulse appears in the cycle after the clock edge that samples the sixth falling edge.
- R3: Six reads of 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0 raise storeReq for one cycle, with the same timing as R2.
- R4: The detector advances only on a falling edge of chip enable, seen as ceN high in one sampled cycle and low in the next. It uses the address present at that edge. Address changes while ceN stays low have no effect.
- R5: A falling edge with weN low is a write. A write sends the detector to step zero, even when its address is 0x0E38.
- R6: busy rises in the same cycle as a request pulse. It stays high for exactly STORE_CYCLES cycles after storeReq, or RECALL_CYCLES cycles after recallReq, and it never rises without a pulse.
- R7: While busy is high, chip-enable falling edges are ignored. They neither advance the detector nor raise a request.
- R8: A read whose address is not the next expected one sends the detector to step zero, with no request. If that address is 0x0E38, it counts as step one of a new run.
- R9: storeReq and recallReq are never high together, and neither stays high for two cycles in a row.
- R10: After a request, the detector is back at step zero. A later run must start again from 0x0E38.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrIn | input | ADDR_W (15) | Bus address, sampled each clock |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| storeReq | output | 1 | One-cycle STORE request |
| recallReq | output | 1 | One-cycle RECALL request |
| busy | output | 1 | High while the modelled operation runs |

## Verification
The bench runs clean RECALL and STORE runs to show that only the sixth address picks the command. It runs a run restarted by a repeated 0x0E38, which must still succeed, and runs broken by a wrong read, which must issue nothing. It also runs runs broken by a write, including a write to 0x0E38, to separate an abort-and-restart from a plain abort. A run presented while busy, followed by only its last two addresses, shows that ignored edges do not advance hidden state. A long chip-enable low phase with a moving address shows that only the falling edge counts.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

  localparam int SEQ_LEN    = 6;
  localparam int PREFIX_LEN = SEQ_LEN - 1;
  localparam int STEP_W     = $clog2(SEQ_LEN);
  localparam int PAT_W      = 15;

  localparam logic [PAT_W-1:0] STORE_TAIL  = 15'h0FC0;
  localparam logic [PAT_W-1:0] RECALL_TAIL = 15'h0C63;

  typedef struct packed {
    logic startStore;
    logic startRecall;
  } ctrlStrobe_t;

  typedef struct packed {
    logic hitNext;
    logic hitHead;
    logic hitStoreEnd;
    logic hitRecallEnd;
  } matchFlags_t;

  // Shared opening addresses, by step index
  function automatic logic [PAT_W-1:0] prefixAddr(input int idx);
    case (idx)
      0:       prefixAddr = 15'h0E38;
      1:       prefixAddr = 15'h31C7;
      2:       prefixAddr = 15'h03E0;
      3:       prefixAddr = 15'h3C1F;
      4:       prefixAddr = 15'h303F;
      default: prefixAddr = '0;
    endcase
  endfunction

endpackage

// File: rtl/nvseq_datapath.sv
module nvseq_datapath
  import nvseq_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int STORE_CYCLES  = 500,
  parameter int RECALL_CYCLES = 1000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic [STEP_W-1:0]   stepIdx,
  input  ctrlStrobe_t         strobe,
  output matchFlags_t         flags,
  output logic                storeReq,
  output logic                recallReq,
  output logic                busy
);

  localparam int MAX_CYC = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [PREFIX_LEN-1:0] prefixHit;
  logic [CNT_W-1:0]      busyCnt;

  // One comparator per opening address
  for (genvar i = 0; i < PREFIX_LEN; i++) begin : g_cmp
    assign prefixHit[i] = (addrIn == ADDR_W'(prefixAddr(i)));
  end

  always_comb begin
    flags              = '0;
    flags.hitHead      = prefixHit[0];
    flags.hitNext      = (int'(stepIdx) < PREFIX_LEN) && prefixHit[stepIdx];
    flags.hitStoreEnd  = (int'(stepIdx) == PREFIX_LEN) && (addrIn == ADDR_W'(STORE_TAIL));
    flags.hitRecallEnd = (int'(stepIdx) == PREFIX_LEN) && (addrIn == ADDR_W'(RECALL_TAIL));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt   <= '0;
      storeReq  <= 1'b0;
      recallReq <= 1'b0;
    end else begin
      storeReq  <= strobe.startStore;
      recallReq <= strobe.startRecall;
      if (strobe.startStore)       busyCnt <= CNT_W'(STORE_CYCLES);
      else if (strobe.startRecall) busyCnt <= CNT_W'(RECALL_CYCLES);
      else if (busyCnt != '0)      busyCnt <= busyCnt - 1'b1;
    end
  end

  assign busy = (busyCnt != '0);

endmodule

// File: rtl/nvseq_ctrl.sv
module nvseq_ctrl
  import nvseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              busy,
  input  matchFlags_t       flags,
  output logic [STEP_W-1:0] stepIdx,
  output ctrlStrobe_t       strobe
);

  logic              ceQ;
  logic              ceFall;
  logic              take;
  logic [STEP_W-1:0] stepNext;

  assign ceFall = ceQ & ~ceN;
  assign take   = ceFall & ~busy;

  always_comb begin
    stepNext = stepIdx;
    strobe   = '0;
    if (take) begin
      if (!weN) begin
        stepNext = '0;
      end else if (flags.hitNext) begin
        stepNext = stepIdx + 1'b1;
      end else if (flags.hitRecallEnd) begin
        strobe.startRecall = 1'b1;
        stepNext           = '0;
      end else if (flags.hitStoreEnd) begin
        strobe.startStore = 1'b1;
        stepNext          = '0;
      end else begin
        stepNext = flags.hitHead ? STEP_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceQ     <= 1'b1;
      stepIdx <= '0;
    end else begin
      ceQ     <= ceN;
      stepIdx <= stepNext;
    end
  end

endmodule

// File: rtl/nvSeqDetect.sv
module nvSeqDetect
  import nvseq_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int STORE_CYCLES  = 500,
  parameter int RECALL_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              ceN,
  input  logic              weN,
  output logic              storeReq,
  output logic              recallReq,
  output logic              busy
);

  logic [STEP_W-1:0] stepIdx;
  ctrlStrobe_t       strobe;
  matchFlags_t       flags;

  nvseq_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .ceN     (ceN),
    .weN     (weN),
    .busy    (busy),
    .flags   (flags),
    .stepIdx (stepIdx),
    .strobe  (strobe)
  );

  nvseq_datapath #(
    .ADDR_W        (ADDR_W),
    .STORE_CYCLES  (STORE_CYCLES),
    .RECALL_CYCLES (RECALL_CYCLES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .addrIn    (addrIn),
    .stepIdx   (stepIdx),
    .strobe    (strobe),
    .flags     (flags),
    .storeReq  (storeReq),
    .recallReq (recallReq),
    .busy      (busy)
  );

endmodule

// File: rtl/nvSeqDetect_chk.sv
module nvSeqDetect_chk #(
  parameter int STORE_CYCLES  = 500,
  parameter int RECALL_CYCLES = 1000
) (
  input logic clk,
  input logic rstN,
  input logic storeReq,
  input logic recallReq,
  input logic busy
);

  logic        anyReq;
  logic        lastStore;
  int unsigned runLen;

  assign anyReq = storeReq | recallReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen    <= 0;
      lastStore <= 1'b0;
    end else if (anyReq) begin
      runLen    <= 1;
      lastStore <= storeReq;
    end else if (busy) begin
      runLen <= runLen + 1;
    end
  end

  // R9: never both requests at once
  a_r9_one_request: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({storeReq, recallReq}));

  // R9: a request lasts a single cycle
  a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |=> !anyReq);

  // R6: busy is up together with the pulse
  a_r6_busy_with_pulse: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |-> busy);

  // R6: busy only rises with a request
  a_r6_rise_needs_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> anyReq);

  // R6: busy length matches the command
  a_r6_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == (lastStore ? STORE_CYCLES : RECALL_CYCLES)));

  // R7: no request issued while already busy
  a_r7_quiet_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |-> !$past(busy));

endmodule

bind nvSeqDetect nvSeqDetect_chk #(
  .STORE_CYCLES  (STORE_CYCLES),
  .RECALL_CYCLES (RECALL_CYCLES)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .storeReq  (storeReq),
  .recallReq (recallReq),
  .busy      (busy)
);

// File: tb/sim_nvSeqDetect.sv
module sim_nvSeqDetect;

  localparam int CLK_PERIOD = 10;
  localparam int ST_CYC     = 60;
  localparam int RC_CYC     = 40;
  localparam int WD_LIMIT   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] addrIn = '0;
  logic        ceN = 1'b1;
  logic        weN = 1'b1;
  logic        storeReq, recallReq, busy;

  int checks = 0;
  int errors = 0;
  int storeSeen = 0;
  int recallSeen = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference model state
  int mStep = 0;
  int mBusyLeft = 0;
  bit mStore = 0, mRecall = 0, mPrevCe = 1;
  logic [14:0] openQ[$] = '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F};

  always #(CLK_PERIOD/2) clk = ~clk;

  nvSeqDetect #(.ADDR_W(15), .STORE_CYCLES(ST_CYC), .RECALL_CYCLES(RC_CYC)) u0 (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .ceN(ceN), .weN(weN),
    .storeReq(storeReq), .recallReq(recallReq), .busy(busy)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStep = 0; mBusyLeft = 0; mStore = 0; mRecall = 0; mPrevCe = 1;
    end else begin
      bit fall, wasBusy;
      fall    = mPrevCe && !ceN;
      wasBusy = mBusyLeft > 0;
      mStore  = 0;
      mRecall = 0;
      if (mBusyLeft > 0) mBusyLeft--;
      if (fall && !wasBusy) begin
        if (!weN) mStep = 0;
        else if (mStep < 5 && addrIn == openQ[mStep]) mStep++;
        else if (mStep == 5 && addrIn == 15'h0C63) begin
          mRecall = 1; mBusyLeft = RC_CYC; mStep = 0;
        end else if (mStep == 5 && addrIn == 15'h0FC0) begin
          mStore = 1; mBusyLeft = ST_CYC; mStep = 0;
        end else mStep = (addrIn == 15'h0E38) ? 1 : 0;
      end
      mPrevCe = ceN;
    end
  end

  // per-cycle comparison against the model (R1 covers the reset cycles)
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (recallReq !== mRecall) begin
        errors++;
        $display("FAIL R2 recallReq actual %b expected %b at cycle %0d", recallReq, mRecall, cycles);
      end
      if (storeReq !== mStore) begin
        errors++;
        $display("FAIL R3 storeReq actual %b expected %b at cycle %0d", storeReq, mStore, cycles);
      end
      if (busy !== (mBusyLeft > 0)) begin
        errors++;
        $display("FAIL R6 busy actual %b expected %b at cycle %0d", busy, (mBusyLeft > 0), cycles);
      end
      if (storeReq === 1'b1) storeSeen++;
      if (recallReq === 1'b1) recallSeen++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WD_LIMIT && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic access(input logic [14:0] a, input bit wr);
    @(posedge clk); #1;
    addrIn = a; weN = ~wr; ceN = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    ceN = 1'b1; weN = 1'b1;
  endtask

  task automatic runReads(input logic [14:0] seq[$]);
    foreach (seq[i]) access(seq[i], 1'b0);
  endtask

  task automatic waitIdle();
    @(posedge clk); #1;
    while (busy) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic clearSeen();
    storeSeen = 0; recallSeen = 0;
  endtask

  task automatic expectSeen(input string tag, input int expS, input int expR);
    checks++;
    if (storeSeen != expS || recallSeen != expR) begin
      errors++;
      $display("FAIL %s pulses actual store=%0d recall=%0d expected store=%0d recall=%0d",
               tag, storeSeen, recallSeen, expS, expR);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet during reset
    checks++;
    if (storeReq !== 1'b0 || recallReq !== 1'b0 || busy !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs actual %b%b%b expected 000", storeReq, recallReq, busy);
    end
    rstN = 1'b1;
    repeat (2) @(posedge clk);

    // R2: clean recall run
    clearSeen();
    runReads('{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F, 15'h0C63});
    waitIdle();
    expectSeen("R2", 0, 1);

    // R3: clean store run
    clearSeen();
    runReads('{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F, 15'h0FC0});
    // R7: a full recall run while still busy must do nothing
    runReads('{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F, 15'h0C63});
    expectSeen("R3", 1, 0);
    waitIdle();
    // R7/R10: only the tail now, must not complete
    clearSeen();
    runReads('{15'h303F, 15'h0C63});
    expectSeen("R7", 0, 0);

    // R8: wrong address mid-run aborts
    clearSeen();
    runReads('{15'h0E38, 15'h31C7, 15'h1234, 15'h3C1F, 15'h303F, 15'h0C63});
    expectSeen("R8", 0, 0);

    // R8: repeated head restarts at step one
    clearSeen();
    runReads('{15'h0E38, 15'h31C7, 15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F, 15'h0C63});
    waitIdle();
    expectSeen("R8", 0, 1);

    // R5: write in the middle aborts
    clearSeen();
    access(15'h0E38, 1'b0);
    access(15'h31C7, 1'b0);
    access(15'h03E0, 1'b1);
    runReads('{15'h3C1F, 15'h303F, 15'h0FC0});
    expectSeen("R5", 0, 0);

    // R5: a write to the head address does not restart
    clearSeen();
    access(15'h0E38, 1'b1);
    runReads('{15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F, 15'h0FC0});
    expectSeen("R5", 0, 0);

    // R4: address moves while ceN stays low, only the edge address counts
    clearSeen();
    @(posedge clk); #1;
    addrIn = 15'h0E38; ceN = 1'b0;
    @(posedge clk); #1; addrIn = 15'h5555;
    @(posedge clk); #1; addrIn = 15'h0C63;
    @(posedge clk); #1; ceN = 1'b1;
    runReads('{15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F, 15'h0FC0});
    waitIdle();
    expectSeen("R4", 1, 0);

    // R10: after a request the run starts over
    clearSeen();
    runReads('{15'h3C1F, 15'h303F, 15'h0FC0});
    expectSeen("R10", 0, 0);

    // R9: back-to-back commands, each a lone pulse
    clearSeen();
    runReads('{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F, 15'h0C63});
    waitIdle();
    runReads('{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F, 15'h0FC0});
    waitIdle();
    expectSeen("R9", 1, 1);

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule